// File: doc/BRIEF.md
# Bus Switch Control and Interrupt Register

This block holds the control and status byte of a four-channel serial-bus switch. The host writes one byte. The low four bits of that byte choose which downstream channels are connected. Any mix of channels, including all or none, may be switched on together. Each channel-enable bit drives one output that would close that channel's pass switch.

Each downstream channel also supplies an active-low interrupt line. The block brings each line into the local clock domain through a two-flop synchronizer. It combines them into one shared interrupt request, presented as an output-enable that pulls an open-drain line low. A register read returns the current enable bits in the low nibble. The high nibble holds the interrupt status, sampled at the moment of the read. A channel raises its interrupt whether or not it is enabled. After reading the status, the host can enable the channel that raised it and service the device.

Top module: `bus_switch_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, every channel-enable output is 0 and the read data byte is 0x00. With all interrupt inputs high, the interrupt output-enable is 0.
- R2: A write puts write-data bit i (i = 0..3) on channel-enable output i. The new value is visible from the clock edge that samples the write strobe.
- R3: Any combination of enable bits is accepted as written, including several at once, all four, and none; no exclusion is applied.
- R4: Write-data bits 7 to 4 have no effect. A later read returns only the written low nibble plus the interrupt status in bits 7 to 4.
- R5: A read returns the channel enables in bits 3 to 0. It returns the interrupt status in bits 7 to 4, where bit 4+i is 1 when interrupt input i (active low) was low at the synchronizer output. The byte is registered on the edge that samples the read strobe.
- R6: The interrupt output-enable is 1 whenever any synchronized interrupt input is low, whichever channels are enabled.
- R7: Several interrupt status bits may read as 1 in the same byte.
- R8: When a write and a read fall in the same cycle, the read returns the newly written enable bits together with the sampled interrupt bits.
- R9: A change on an interrupt input reaches the interrupt output-enable after exactly two clock edges. It has not arrived after one.
- R10: The read data byte holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte; bits 3..0 are channel enables |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data byte: interrupt status 7..4, enables 3..0 |
| chan_en | output | 4 | Channel-enable outputs, 1 = connected |
| irq_n_in | input | 4 | Per-channel interrupt inputs, active low |
| irq_oe | output | 1 | Shared interrupt pull-down enable, 1 = drive line low |

## Verification
A write and a read can fall in the same cycle. The bench provokes this by raising both strobes together while interrupt inputs are held low. It then judges the registered byte: the low nibble must carry the new enables and not the old ones, and the high nibble must carry the synchronized interrupt pattern. The interrupt combining path is also checked in the same period. An interrupt on a disabled channel must assert the shared output while enables change underneath it.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
    localparam int NUM_CH      = 4;
    localparam int SYNC_STAGES = 2;
    localparam int WORD_W      = 2 * NUM_CH;

    typedef logic [NUM_CH-1:0] ch_vec_t;

    typedef struct packed {
        ch_vec_t irq_stat;
        ch_vec_t enables;
    } ctrl_word_t;

    function automatic ctrl_word_t build_word(input ch_vec_t stat, input ch_vec_t en);
        ctrl_word_t w;
        w.irq_stat = stat;
        w.enables  = en;
        return w;
    endfunction

    function automatic ch_vec_t enable_field(input logic [WORD_W-1:0] raw);
        return raw[NUM_CH-1:0];
    endfunction
endpackage

// File: rtl/bsw_irq_sync.sv
module bsw_irq_sync
    import bsw_pkg::*;
#(
    parameter int CH     = NUM_CH,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] irq_n_raw,
    output logic [CH-1:0] irq_active
);
    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], irq_n_raw[c]};
        end
        assign irq_active[c] = ~chain[STAGES-1];
    end
endmodule

// File: rtl/bsw_enable_reg.sv
module bsw_enable_reg
    import bsw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output ch_vec_t             en_next,
    output ch_vec_t             en_q
);
    always_comb en_next = wr_en ? enable_field(wr_data) : en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_next;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> en_q == $past(wr_data[NUM_CH-1:0])); // R2
endmodule

// File: rtl/bus_switch_ctrl.sv
module bus_switch_ctrl
    import bsw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    output logic [3:0]  chan_en,
    input  logic [3:0]  irq_n_in,
    output logic        irq_oe
);
    ch_vec_t    irq_active;
    ch_vec_t    en_next;
    ch_vec_t    en_q;
    ctrl_word_t rd_q;

    bsw_irq_sync #(.CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .irq_n_raw  (irq_n_in),
        .irq_active (irq_active)
    );

    bsw_enable_reg u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .en_next (en_next),
        .en_q    (en_q)
    );

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= build_word(irq_active, en_next);
    end

    assign rd_data = rd_q;
    assign chan_en = en_q;
    assign irq_oe  = |irq_active;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (chan_en == '0 && rd_data == '0)); // R1
    AST_READ_SEES_NEW: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_data[3:0] == chan_en); // R8
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R10
    AST_QUIET_STATUS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !irq_oe) |=> rd_data[7:4] == '0); // R6
endmodule

// File: tb/bus_switch_ctrl_test.sv
module bus_switch_ctrl_test;
    logic       clk = 0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [7:0] rd_data;
    logic [3:0] chan_en;
    logic [3:0] irq_n_in;
    logic       irq_oe;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    bus_switch_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .chan_en(chan_en),
        .irq_n_in(irq_n_in), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        tick();
        wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic do_read(output logic [7:0] d);
        rd_en = 1;
        tick();
        rd_en = 0;
        d = rd_data;
    endtask

    task automatic t_reset();
        rst = 1; wr_en = 0; wr_data = 0; rd_en = 0; irq_n_in = 4'hF;
        tick(); tick();
        check("R1 chan_en in reset", {4'h0, chan_en}, 8'h00);
        check("R1 rd_data in reset", rd_data, 8'h00);
        rst = 0;
        tick();
        check("R1 chan_en after reset", {4'h0, chan_en}, 8'h00);
        check("R1 irq_oe after reset", {7'h0, irq_oe}, 8'h00);
    endtask

    task automatic t_write_patterns();
        logic [7:0] r;
        do_write(8'h01);
        check("R2 single channel 0", {4'h0, chan_en}, 8'h01);
        do_write(8'h08);
        check("R2 single channel 3", {4'h0, chan_en}, 8'h08);
        do_write(8'h06);
        check("R3 two channels", {4'h0, chan_en}, 8'h06);
        do_write(8'h0F);
        check("R3 all channels", {4'h0, chan_en}, 8'h0F);
        do_write(8'h00);
        check("R3 no channel", {4'h0, chan_en}, 8'h00);
        do_write(8'hA5);
        check("R4 upper write bits ignored, enables", {4'h0, chan_en}, 8'h05);
        do_read(r);
        check("R4 read after upper-bit write", r, 8'h05);
    endtask

    task automatic t_irq_path();
        logic [7:0] r;
        do_write(8'h00);
        irq_n_in = 4'b1101;
        tick();
        check("R9 irq_oe not yet after one edge", {7'h0, irq_oe}, 8'h00);
        tick();
        check("R9 irq_oe after two edges", {7'h0, irq_oe}, 8'h01);
        check("R6 irq on disabled channel", {7'h0, irq_oe}, 8'h01);
        do_read(r);
        check("R5 status bit 5 for channel 1", r, 8'h20);
        irq_n_in = 4'b0110;
        tick(); tick();
        do_read(r);
        check("R7 multiple status bits", r, 8'h90);
        tick(); tick();
        check("R10 rd_data held without strobe", rd_data, 8'h90);
        irq_n_in = 4'hF;
        tick();
        check("R9 irq_oe still set one edge after release", {7'h0, irq_oe}, 8'h01);
        tick();
        check("R6 irq_oe released", {7'h0, irq_oe}, 8'h00);
    endtask

    task automatic t_same_cycle();
        do_write(8'h03);
        irq_n_in = 4'b1110;
        tick(); tick();
        wr_en = 1; wr_data = 8'h0C; rd_en = 1;
        tick();
        wr_en = 0; wr_data = 0; rd_en = 0;
        check("R8 same-cycle write and read", rd_data, 8'h1C);
        check("R8 enables after same-cycle", {4'h0, chan_en}, 8'h0C);
        irq_n_in = 4'hF;
        tick(); tick();
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_write_patterns();
        t_irq_path();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule